// File: doc/BRIEF.md
# Two-State Bus Cycle Controller

This block is a bus master sequencer clocked by a fast input clock running at twice the bus state rate. It splits that clock into two alternating phases. Each bus state lasts one phase-1 cycle and one phase-2 cycle. The block turns requests into bus cycles made of one address state (T1) and one or more response states (T2). When no work is waiting, it rests in an idle state (Ti).

A requester presents an address, a 16-bit write word and a cycle-type code with a one-cycle strobe. A one-entry holding slot keeps that request until the sequencer can start it. On the bus side the block drives:
- an active-low address strobe;
- address, status and write data lines;
- a phase clock that is high in phase 1.

The block samples ready only at the end of phase 2 of each response state. A local-bus select input picks where ready comes from: an internal ready source or an external active-low pin. When the cycle ends, the block captures the read word and raises a one-cycle completion pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is low, the strobe is high, completion is low and the request slot reports empty. The phase clock alternates on every fast cycle. The first fast cycle after the first rising edge that sees reset released is phase 1 (phase clock high).
- R2: The address strobe goes low only at the start of a phase-1 cycle and stays low for exactly two fast cycles (state T1).
- R3: Address, status and write data show the request's values from the first strobe-low cycle. They stay unchanged until the completion pulse.
- R4: With ready seen at the first sample, completion is high in the fourth fast cycle after the first strobe-low cycle, which counts as cycle 0 (zero wait states).
- R5: Each sample that finds ready not asserted adds one T2 state, so completion is high in cycle 4+2W for W wait states.
- R6: With local-bus select low, ready is the active-high internal input, and the external pin has no effect on cycle length.
- R7: With local-bus select high, ready is the active-low external pin, and the internal input has no effect on cycle length.
- R8: The read-data output holds the bus input word present in the terminating sample cycle (cycle 3+2W). It shows that word together with the completion pulse.
- R9: Completion is high for exactly one fast cycle, and that cycle is in phase 1.
- R10: If a request is waiting when a cycle ends, the strobe is low in the completion cycle, carrying the new address, with no idle state between the two cycles.
- R11: Ready asserted only during phase 1 of a T2 state does not end the cycle.
- R12: The slot accepts a strobe only while it reports ready. It reports not-ready from the cycle after acceptance until its request starts on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, twice the bus state rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Request write word |
| req_type_i | input | SW | Request cycle-type code |
| req_rdy_o | output | 1 | Holding slot is empty |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read word |
| ads_n_o | output | 1 | Active-low address strobe |
| addr_o | output | AW | Bus address |
| stat_o | output | SW | Bus status (cycle type) |
| wdata_o | output | DW | Bus write word |
| bus_din_i | input | DW | Bus read word |
| ext_rdy_n_i | input | 1 | External active-low ready |
| int_rdy_i | input | 1 | Internal active-high ready |
| lba_n_i | input | 1 | Local-bus select, low picks internal ready |
| phclk_o | output | 1 | Phase clock, high in phase 1 |

## Verification
The bench builds the block with its default widths (24-bit address, 16-bit data, 3-bit status). These widths are small enough to check every bus field directly on each transfer. It sweeps every combination of wait count 0 to 4, both ready sources, and phase-1-only ready pulses. It holds the unused ready source asserted throughout, so a source that should be ignored would shorten the cycle. The read bus input changes every cycle, which pins down the exact capture cycle. A chained pair of transfers covers the direct T2-to-T1 path and the busy period of the holding slot.

// File: rtl/bcs_pkg.sv
// Shared types for the bus cycle sequencer.
package bcs_pkg;
    // Bus state of the sequencer: idle, address state, response state.
    typedef enum logic [1:0] {
        BS_TI = 2'd0,
        BS_T1 = 2'd1,
        BS_T2 = 2'd2
    } bus_state_e;
endpackage

// File: rtl/bcs_phase_gen.sv
// Phase generator: divides the fast clock into phase 1 / phase 2.
// Assumes: reset is synchronous active-low; the first edge that sees reset
// released starts phase 1, which fixes the phase alignment to reset.
module bcs_phase_gen (
    input  logic clk2x,
    input  logic rst_n,
    output logic ph2_o,
    output logic phclk_o
);
    logic ph2_q;

    // Phase toggle; held at phase 2 in reset so release lands on phase 1.
    always_ff @(posedge clk2x) begin
        if (!rst_n) ph2_q <= 1'b1;
        else        ph2_q <= ~ph2_q;
    end

    assign ph2_o   = ph2_q;
    assign phclk_o = ~ph2_q;
endmodule

// File: rtl/bcs_ready_sel.sv
// Ready source selector: local-bus select low takes the internal active-high
// ready, otherwise the external active-low pin. Output is active-high.
// Assumes: both sources are already synchronous to the fast clock.
module bcs_ready_sel (
    input  logic lba_n_i,
    input  logic ext_rdy_n_i,
    input  logic int_rdy_i,
    output logic rdy_o
);
    // Pick one source; the other one has no path to the output.
    always_comb begin
        if (!lba_n_i) rdy_o = int_rdy_i;
        else          rdy_o = ~ext_rdy_n_i;
    end
endmodule

// File: rtl/bcs_req_slot.sv
// One-entry request holding slot between the requester and the sequencer.
// Assumes: the requester only strobes while ready_o is high; a strobe
// while full is dropped.
module bcs_req_slot #(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int SW = 3
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [SW-1:0] type_i,
    input  logic          take_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [SW-1:0] type_o,
    output logic          ready_o
);
    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [SW-1:0] type_q;

    // Occupancy flag: set on an accepted strobe, cleared when started.
    always_ff @(posedge clk2x) begin
        if (!rst_n)                  valid_q <= 1'b0;
        else if (take_i)             valid_q <= 1'b0;
        else if (req_i && !valid_q)  valid_q <= 1'b1;
    end

    // Payload capture on acceptance only.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            type_q  <= '0;
        end else if (req_i && !valid_q) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            type_q  <= type_i;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign type_o  = type_q;
    assign ready_o = ~valid_q;
endmodule

// File: rtl/bcs_fsm.sv
// Bus state sequencer: Ti / T1 / T2 with a sampled-ready wait loop.
// State changes only on the edge that ends phase 2. Ready is looked at
// only on that edge while in T2. A waiting request starts straight from
// the terminating T2.
// Assumes: ph2_i is high in the phase-2 fast cycle of each bus state.
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int SW = 3
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          ph2_i,
    input  logic          rdy_i,
    input  logic          pend_i,
    input  logic [AW-1:0] pend_addr_i,
    input  logic [DW-1:0] pend_wdata_i,
    input  logic [SW-1:0] pend_type_i,
    input  logic [DW-1:0] bus_din_i,
    output logic          take_o,
    output bus_state_e    state_o,
    output logic          ads_n_o,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] stat_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    bus_state_e    st_q, st_d;
    logic          term, launch;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] stat_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          done_q;

    // Termination and launch decisions at the end of phase 2.
    always_comb begin
        term   = (st_q == BS_T2) && ph2_i && rdy_i;
        launch = ph2_i && pend_i && ((st_q == BS_TI) || term);
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        if (ph2_i) begin
            unique case (st_q)
                BS_TI:   if (pend_i) st_d = BS_T1;
                BS_T1:   st_d = BS_T2;
                BS_T2:   if (rdy_i)  st_d = pend_i ? BS_T1 : BS_TI;
                default: st_d = BS_TI;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk2x) begin
        if (!rst_n) st_q <= BS_TI;
        else        st_q <= st_d;
    end

    // Bus-side address, status and write word, loaded as T1 begins.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            addr_q  <= '0;
            stat_q  <= '0;
            wdata_q <= '0;
        end else if (launch) begin
            addr_q  <= pend_addr_i;
            stat_q  <= pend_type_i;
            wdata_q <= pend_wdata_i;
        end
    end

    // Read capture and completion pulse on the terminating sample.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= term;
            if (term) rdata_q <= bus_din_i;
        end
    end

    assign take_o  = launch;
    assign state_o = st_q;
    assign ads_n_o = (st_q != BS_T1);
    assign addr_o  = addr_q;
    assign stat_o  = stat_q;
    assign wdata_o = wdata_q;
    assign rdata_o = rdata_q;
    assign done_o  = done_q;
endmodule

// File: rtl/bus_cycle_seq.sv
// Top of the two-state bus cycle controller. Ties together the phase
// generator, the ready selector, the request slot and the sequencer.
// Assumes: every input is synchronous to clk2x.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int SW = 3
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [SW-1:0] req_type_i,
    output logic          req_rdy_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o,
    output logic          ads_n_o,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] stat_o,
    output logic [DW-1:0] wdata_o,
    input  logic [DW-1:0] bus_din_i,
    input  logic          ext_rdy_n_i,
    input  logic          int_rdy_i,
    input  logic          lba_n_i,
    output logic          phclk_o
);
    logic          ph2;
    logic          rdy;
    logic          pend_valid, take;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_wdata;
    logic [SW-1:0] pend_type;
    bus_state_e    bus_st;

    bcs_phase_gen u_phase (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .ph2_o   (ph2),
        .phclk_o (phclk_o)
    );

    bcs_ready_sel u_rdy (
        .lba_n_i     (lba_n_i),
        .ext_rdy_n_i (ext_rdy_n_i),
        .int_rdy_i   (int_rdy_i),
        .rdy_o       (rdy)
    );

    bcs_req_slot #(.AW(AW), .DW(DW), .SW(SW)) u_slot (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .addr_i  (req_addr_i),
        .wdata_i (req_wdata_i),
        .type_i  (req_type_i),
        .take_i  (take),
        .valid_o (pend_valid),
        .addr_o  (pend_addr),
        .wdata_o (pend_wdata),
        .type_o  (pend_type),
        .ready_o (req_rdy_o)
    );

    bcs_fsm #(.AW(AW), .DW(DW), .SW(SW)) u_fsm (
        .clk2x        (clk2x),
        .rst_n        (rst_n),
        .ph2_i        (ph2),
        .rdy_i        (rdy),
        .pend_i       (pend_valid),
        .pend_addr_i  (pend_addr),
        .pend_wdata_i (pend_wdata),
        .pend_type_i  (pend_type),
        .bus_din_i    (bus_din_i),
        .take_o       (take),
        .state_o      (bus_st),
        .ads_n_o      (ads_n_o),
        .addr_o       (addr_o),
        .stat_o       (stat_o),
        .wdata_o      (wdata_o),
        .rdata_o      (rdata_o),
        .done_o       (done_o)
    );
endmodule

// File: rtl/bcs_checker.sv
// Protocol checker for bus_cycle_seq, attached by bind.
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int AW = 24,
    parameter int SW = 3
) (
    input logic          clk2x,
    input logic          rst_n,
    input logic          ads_n_o,
    input logic [AW-1:0] addr_o,
    input logic [SW-1:0] stat_o,
    input logic          done_o,
    input logic          phclk_o,
    input bus_state_e    bus_st
);
    // R1: phase clock alternates every fast cycle.
    a_r1_phase_toggle: assert property (@(posedge clk2x) disable iff (!rst_n)
        1'b1 |=> (phclk_o != $past(phclk_o)));

    // R2: strobe falls only in phase 1.
    a_r2_ads_in_ph1: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(ads_n_o) |-> phclk_o);

    // R2: strobe stays low for the second cycle.
    a_r2_ads_second: assert property (@(posedge clk2x) disable iff (!rst_n)
        $fell(ads_n_o) |=> !ads_n_o);

    // R2: strobe releases after two low cycles.
    a_r2_ads_release: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!ads_n_o && $past(!ads_n_o)) |=> ads_n_o);

    // R3: address and status hold through response states.
    a_r3_bus_hold: assert property (@(posedge clk2x) disable iff (!rst_n)
        (bus_st == BS_T2) |-> ($stable(addr_o) && $stable(stat_o)));

    // R9: completion lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk2x) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: completion falls in phase 1.
    a_r9_done_ph1: assert property (@(posedge clk2x) disable iff (!rst_n)
        done_o |-> phclk_o);
endmodule

bind bus_cycle_seq bcs_checker #(.AW(AW), .SW(SW)) u_chk (
    .clk2x   (clk2x),
    .rst_n   (rst_n),
    .ads_n_o (ads_n_o),
    .addr_o  (addr_o),
    .stat_o  (stat_o),
    .done_o  (done_o),
    .phclk_o (phclk_o),
    .bus_st  (bus_st)
);

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [SW-1:0] req_type;
    logic          req_rdy, done, ads_n, phclk;
    logic [DW-1:0] rdata, wdata, bus_din;
    logic [AW-1:0] addr;
    logic [SW-1:0] stat;
    logic          ext_rdy_n, int_rdy, lba_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW), .SW(SW)) dut (
        .clk2x(clk), .rst_n(rst_n), .req_i(req), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .req_type_i(req_type), .req_rdy_o(req_rdy),
        .done_o(done), .rdata_o(rdata), .ads_n_o(ads_n), .addr_o(addr),
        .stat_o(stat), .wdata_o(wdata), .bus_din_i(bus_din),
        .ext_rdy_n_i(ext_rdy_n), .int_rdy_i(int_rdy), .lba_n_i(lba_n),
        .phclk_o(phclk)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Drive the selected source with 'lo' and hold the other one asserted.
    task automatic set_ready(input bit sel, input bit lo);
        if (!sel) begin
            int_rdy   = lo;
            ext_rdy_n = 1'b0;
        end else begin
            ext_rdy_n = ~lo;
            int_rdy   = 1'b1;
        end
    endtask

    task automatic issue(input [AW-1:0] a, input [DW-1:0] d, input [SW-1:0] t);
        int guard;
        @(negedge clk);
        while (!req_rdy) @(negedge clk);
        req = 1'b1; req_addr = a; req_wdata = d; req_type = t;
        @(negedge clk);
        req = 1'b0;
        if (ads_n) chk(req_rdy == 1'b0, "R12", "slot busy after accept", req_rdy, 0);
        guard = 0;
        while (ads_n && guard < 20) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Runs one bus cycle starting at the negedge of its first strobe-low cycle.
    task automatic body(input [AW-1:0] a, input [DW-1:0] d, input [SW-1:0] t,
                        input int w, input bit sel, input bit glitch,
                        input bit chain, input [AW-1:0] na);
        int idx;
        bit lo;
        bit hold_ok;
        logic [DW-1:0] exp_rd;
        string src;
        idx = 0;
        hold_ok = 1'b1;
        exp_rd = '0;
        src = sel ? "R7" : "R6";
        lba_n = sel;
        chk(ads_n == 1'b0, "R2", "strobe low at start", ads_n, 0);
        chk(phclk == 1'b1, "R2", "start in phase 1", phclk, 1);
        chk(addr == a, "R3", "address", addr, a);
        chk(stat == t, "R3", "status", stat, t);
        chk(wdata == d, "R3", "write word", wdata, d);
        if (chain) begin
            req = 1'b1; req_addr = na; req_wdata = ~d; req_type = ~t;
        end
        while (1) begin
            lo = (idx == 3 + 2*w) ||
                 (glitch && idx >= 2 && idx < 3 + 2*w && (idx % 2) == 0);
            set_ready(sel, lo);
            bus_din = DW'(16'h3C00 + idx * 37);
            if (idx == 3 + 2*w) exp_rd = bus_din;
            @(negedge clk);
            idx++;
            if (chain && idx == 1) begin
                req = 1'b0;
                chk(req_rdy == 1'b0, "R12", "slot busy with queued request", req_rdy, 0);
            end
            if (idx == 1) chk(ads_n == 1'b0, "R2", "strobe second cycle", ads_n, 0);
            if (idx == 2) chk(ads_n == 1'b1, "R2", "strobe released", ads_n, 1);
            if (done || idx > 40) break;
            if (addr != a || stat != t || wdata != d) hold_ok = 1'b0;
        end
        chk(hold_ok, "R3", "bus fields held", hold_ok, 1);
        chk(idx == 4 + 2*w, (w == 0) ? "R4" : "R5", "completion cycle", idx, 4 + 2*w);
        chk(idx == 4 + 2*w, src, "ready source length", idx, 4 + 2*w);
        if (glitch) chk(idx == 4 + 2*w, "R11", "phase-1 ready ignored", idx, 4 + 2*w);
        chk(rdata == exp_rd, "R8", "read word", rdata, exp_rd);
        chk(phclk == 1'b1, "R9", "completion in phase 1", phclk, 1);
        if (chain) begin
            chk(ads_n == 1'b0, "R10", "direct restart strobe", ads_n, 0);
            chk(addr == na, "R10", "direct restart address", addr, na);
        end
    endtask

    initial begin
        rst_n = 1'b0; req = 1'b0; req_addr = '0; req_wdata = '0; req_type = '0;
        bus_din = '0; ext_rdy_n = 1'b1; int_rdy = 1'b0; lba_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ads_n == 1'b1, "R1", "strobe in reset", ads_n, 1);
        chk(done == 1'b0, "R1", "completion in reset", done, 0);
        chk(req_rdy == 1'b1, "R1", "slot empty in reset", req_rdy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(phclk == 1'b1, "R1", "first cycle phase 1", phclk, 1);
        @(negedge clk);
        chk(phclk == 1'b0, "R1", "second cycle phase 2", phclk, 0);
        @(negedge clk);
        chk(phclk == 1'b1, "R1", "third cycle phase 1", phclk, 1);

        for (int w = 0; w <= 4; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int g = 0; g < 2; g++) begin
                    logic [AW-1:0] a;
                    logic [DW-1:0] d;
                    logic [SW-1:0] t;
                    a = AW'(24'h1000 * (w + 1) + 16 * s + g);
                    d = DW'(16'hA500 + 8 * w + 2 * s + g);
                    t = SW'(w + s + g);
                    issue(a, d, t);
                    body(a, d, t, w, s[0], g[0], 1'b0, '0);
                    ext_rdy_n = 1'b1; int_rdy = 1'b0;
                    @(negedge clk);
                    chk(done == 1'b0, "R9", "completion one cycle", done, 0);
                    chk(ads_n == 1'b1, "R1", "idle after lone cycle", ads_n, 1);
                end
            end
        end

        // Chained pair: second request waits while the first runs.
        issue(24'hABCDE0, 16'h1234, 3'd5);
        body(24'hABCDE0, 16'h1234, 3'd5, 1, 1'b1, 1'b0, 1'b1, 24'h0F0F01);
        body(24'h0F0F01, ~16'h1234, ~3'd5, 0, 1'b0, 1'b0, 1'b0, '0);
        ext_rdy_n = 1'b1; int_rdy = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9", "completion one cycle after chain", done, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule